// File: doc/BRIEF.md
# OLED Command and Data Byte Parser

This block sits behind a two-wire target front end that has already matched the address and split the transfer into bytes. Each received byte arrives with a one-cycle valid strobe, and separate strobes mark the start and stop conditions of a transfer. The parser classifies every byte in one of four ways: a selector that opens command or data mode, a command opcode, a parameter that is thrown away, or a pixel byte for the frame memory. It keeps the drawing position (an 8-bit column, a 3-bit page and a 6-bit scan start line) and four display flags: horizontal flip, force-all-lit, inverted, and panel enabled.

Pixel bytes leave the block through a registered write port into a page-organised frame memory of 132 columns by 8 pages. The column advances after every pixel byte. Commands for brightness, timing and power are accepted. Those that carry a parameter swallow their next command byte without decoding it. Malformed selectors and unknown opcodes each produce a one-cycle error pulse, and the parser keeps running afterwards. A redraw pulse tells the display scan-out logic when the picture may have changed. Read requests are answered only with an "unsupported" pulse.

Top module: `oled_byte_parser`

## Requirements
- R1: After reset, column, page and start line are 0, all four display flags are 0, the parser is in selector mode, and no write, error or redraw pulse is active.
- R2: In selector mode, byte 0x80 enters command mode and byte 0x40 enters data mode. Any other byte leaves the parser in selector mode and raises `sel_err` for exactly one cycle, in the cycle after the byte.
- R3: In data mode, each byte is written at address page*132 + column. `mem_we`, `mem_addr` and `mem_wdata` are valid in the cycle after the byte. The column then advances by one, the page is unchanged, and data mode persists until a start or stop event.
- R4: A pixel byte taken at column 131 sets the column to 0 afterwards. A pixel byte taken at a column of 132 or more is not written and also sets the column to 0.
- R5: After one command byte is handled, the parser returns to selector mode, so the next byte is treated as a selector.
- R6: Opcodes 0x00 to 0x0F replace column bits [3:0] with opcode bits [3:0]. Opcodes 0x10 to 0x20 replace column bits [7:4] with opcode bits [3:0]. In both cases the other nibble is kept.
- R7: Opcodes 0x40 to 0x7F load the start line from opcode bits [5:0]. Opcodes 0xB0 to 0xBF load the page from opcode bits [2:0].
- R8: Opcode bit 0 is the new flag value for these pairs: 0xA0/0xA1 set flip, 0xA4/0xA5 set force-all-lit, 0xA6/0xA7 set inverted, and 0xAE/0xAF set panel enabled.
- R9: Opcodes 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB arm a skip. The next byte taken in command mode is then discarded without decoding or error, and the parser returns to selector mode.
- R10: Opcodes 0xC0 to 0xC8 and 0xE3 change no state and raise no error.
- R11: Any opcode not covered by R6 to R10 changes no state and raises `cmd_err` for exactly one cycle. The parser keeps running afterwards.
- R12: A start or stop event returns the parser to selector mode and clears any armed skip. A byte strobed in the same cycle as an event is dropped.
- R13: A `read_req` strobe raises `rd_unsup` for exactly one cycle, in the next cycle.
- R14: `redraw` pulses for one cycle together with every frame memory write, and in the cycle after a flag or start-line command that changes the stored value. A command that rewrites the same value does not pulse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| start_evt | input | 1 | Transfer start event |
| stop_evt | input | 1 | Transfer stop event |
| read_req | input | 1 | Read attempt strobe |
| mem_we | output | 1 | Frame memory write enable |
| mem_addr | output | 11 | Frame memory byte address |
| mem_wdata | output | 8 | Frame memory write data |
| col_ptr | output | 8 | Current column |
| page_ptr | output | 3 | Current page |
| start_line | output | 6 | Scan start line |
| flip | output | 1 | Horizontal flip flag |
| all_lit | output | 1 | Force-all-lit flag |
| invert | output | 1 | Inverted flag |
| panel_en | output | 1 | Panel enabled flag |
| sel_err | output | 1 | Bad selector pulse |
| cmd_err | output | 1 | Unknown opcode pulse |
| rd_unsup | output | 1 | Unsupported read pulse |
| redraw | output | 1 | Redraw request pulse |

## Verification
Pixel streams are sent from a column in mid-page, across the last column, and from a column past the end of a page. Together these separate correct address arithmetic from off-by-one wrap errors and from writes that should have been suppressed. Parameter-taking opcodes are followed by a parameter that would itself be a valid page command. If that byte leaks into the decoder, the page changes visibly, so a broken skip shows up at the ports. Bad selectors, unknown opcodes, ignored opcodes, selectors sent straight after a command, and bytes after a stop event each have a distinct signature on the error, flag and write outputs. Flag commands are issued twice to tell a redraw on a real change apart from a redraw on every command.

// File: rtl/oled_parser_pkg.sv
package oled_parser_pkg;
  localparam int COL_W = 8;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CMD  = 2'd1,
    MODE_DATA = 2'd2
  } mode_e;

  typedef enum logic [3:0] {
    OP_LOWCOL, OP_HICOL, OP_START, OP_PAGE, OP_FLIP, OP_ALLLIT,
    OP_INV, OP_EN, OP_PARAM, OP_NOP, OP_BAD
  } op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    logic     setval;
  } op_t;
endpackage

// File: rtl/oled_opcode_decode.sv
module oled_opcode_decode
  import oled_parser_pkg::*;
(
  input  logic [7:0] op,
  output op_t        dec
);
  always_comb begin
    dec.setval = op[0];
    dec.kind   = OP_BAD;
    if (op <= 8'h0F)                      dec.kind = OP_LOWCOL;
    else if (op <= 8'h20)                 dec.kind = OP_HICOL;
    else if (op >= 8'h40 && op <= 8'h7F)  dec.kind = OP_START;
    else if (op >= 8'hB0 && op <= 8'hBF)  dec.kind = OP_PAGE;
    else if (op >= 8'hC0 && op <= 8'hC8)  dec.kind = OP_NOP;
    else begin
      case (op)
        8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
        8'hD8, 8'hD9, 8'hDA, 8'hDB:        dec.kind = OP_PARAM;
        8'hA0, 8'hA1:                      dec.kind = OP_FLIP;
        8'hA4, 8'hA5:                      dec.kind = OP_ALLLIT;
        8'hA6, 8'hA7:                      dec.kind = OP_INV;
        8'hAE, 8'hAF:                      dec.kind = OP_EN;
        8'hE3:                             dec.kind = OP_NOP;
        default:                           dec.kind = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/oled_mode_fsm.sv
module oled_mode_fsm
  import oled_parser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       needs_param,
  output logic       cmd_fire,
  output logic       data_fire,
  output logic       sel_err
);
  mode_e mode_q, mode_d;
  logic  skip_q, skip_d;
  logic  sel_err_q, sel_err_d;
  logic  evt;

  assign evt = start_evt | stop_evt;

  always_comb begin
    mode_d    = mode_q;
    skip_d    = skip_q;
    sel_err_d = 1'b0;
    cmd_fire  = 1'b0;
    data_fire = 1'b0;
    if (evt) begin
      mode_d = MODE_IDLE;
      skip_d = 1'b0;
    end else if (byte_valid) begin
      case (mode_q)
        MODE_IDLE: begin
          if (byte_data == 8'h80)      mode_d = MODE_CMD;
          else if (byte_data == 8'h40) mode_d = MODE_DATA;
          else                         sel_err_d = 1'b1;
        end
        MODE_CMD: begin
          mode_d = MODE_IDLE;
          if (skip_q) begin
            skip_d = 1'b0;
          end else begin
            cmd_fire = 1'b1;
            skip_d   = needs_param;
          end
        end
        MODE_DATA: data_fire = 1'b1;
        default:   mode_d = MODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_IDLE;
      skip_q    <= 1'b0;
      sel_err_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      skip_q    <= skip_d;
      sel_err_q <= sel_err_d;
    end
  end

  assign sel_err = sel_err_q;

  AST_EVENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (mode_q == MODE_IDLE)) else $error("event did not idle parser"); // R12

  AST_CMD_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !evt && mode_q == MODE_CMD) |=> (mode_q == MODE_IDLE)) else $error("command mode persisted"); // R5
endmodule

// File: rtl/oled_disp_state.sv
module oled_disp_state
  import oled_parser_pkg::*;
#(
  parameter int COLS   = 132,
  parameter int PAGES  = 8,
  parameter int LINE_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_fire,
  input  logic                       data_fire,
  input  logic [7:0]                 byte_data,
  input  op_t                        dec,
  output logic                       mem_we,
  output logic [$clog2(COLS*PAGES)-1:0] mem_addr,
  output logic [7:0]                 mem_wdata,
  output logic [COL_W-1:0]           col_ptr,
  output logic [$clog2(PAGES)-1:0]   page_ptr,
  output logic [LINE_W-1:0]          start_line,
  output logic                       flip,
  output logic                       all_lit,
  output logic                       invert,
  output logic                       panel_en,
  output logic                       cmd_err,
  output logic                       redraw
);
  localparam int ADDR_W  = $clog2(COLS*PAGES);
  localparam int PAGE_W  = $clog2(PAGES);
  localparam int TOTAL   = COLS*PAGES;
  localparam logic [COL_W-1:0] NCOLS    = COL_W'(COLS);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS-1);

  logic [COL_W-1:0]  col_q, col_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic flip_q, flip_d, lit_q, lit_d, inv_q, inv_d, en_q, en_d;
  logic we_q, we_d, cerr_q, cerr_d, redraw_q, redraw_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0] wdata_q, wdata_d;
  logic upd_en;

  assign upd_en = cmd_fire | data_fire;

  always_comb begin
    col_d    = col_q;
    page_d   = page_q;
    line_d   = line_q;
    flip_d   = flip_q;
    lit_d    = lit_q;
    inv_d    = inv_q;
    en_d     = en_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    we_d     = 1'b0;
    cerr_d   = 1'b0;
    redraw_d = 1'b0;
    if (data_fire) begin
      if (col_q < NCOLS) begin
        we_d     = 1'b1;
        addr_d   = ADDR_W'(page_q) * ADDR_W'(COLS) + ADDR_W'(col_q);
        wdata_d  = byte_data;
        redraw_d = 1'b1;
      end
      col_d = (col_q >= LAST_COL) ? '0 : col_q + 1'b1;
    end else if (cmd_fire) begin
      case (dec.kind)
        OP_LOWCOL: col_d  = {col_q[COL_W-1:4], byte_data[3:0]};
        OP_HICOL:  col_d  = {byte_data[3:0], col_q[3:0]};
        OP_PAGE:   page_d = byte_data[PAGE_W-1:0];
        OP_START: begin
          line_d   = byte_data[LINE_W-1:0];
          redraw_d = (line_q != byte_data[LINE_W-1:0]);
        end
        OP_FLIP: begin
          flip_d   = dec.setval;
          redraw_d = (flip_q != dec.setval);
        end
        OP_ALLLIT: begin
          lit_d    = dec.setval;
          redraw_d = (lit_q != dec.setval);
        end
        OP_INV: begin
          inv_d    = dec.setval;
          redraw_d = (inv_q != dec.setval);
        end
        OP_EN: begin
          en_d     = dec.setval;
          redraw_d = (en_q != dec.setval);
        end
        OP_BAD:    cerr_d = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      page_q <= '0;
      line_q <= '0;
      flip_q <= 1'b0;
      lit_q  <= 1'b0;
      inv_q  <= 1'b0;
      en_q   <= 1'b0;
      addr_q <= '0;
      wdata_q <= '0;
    end else if (upd_en) begin
      col_q  <= col_d;
      page_q <= page_d;
      line_q <= line_d;
      flip_q <= flip_d;
      lit_q  <= lit_d;
      inv_q  <= inv_d;
      en_q   <= en_d;
      addr_q <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b0;
      cerr_q   <= 1'b0;
      redraw_q <= 1'b0;
    end else begin
      we_q     <= we_d;
      cerr_q   <= cerr_d;
      redraw_q <= redraw_d;
    end
  end

  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign col_ptr    = col_q;
  assign page_ptr   = page_q;
  assign start_line = line_q;
  assign flip       = flip_q;
  assign all_lit    = lit_q;
  assign invert     = inv_q;
  assign panel_en   = en_q;
  assign cmd_err    = cerr_q;
  assign redraw     = redraw_q;

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && col_q == LAST_COL) |=> (col_q == '0)) else $error("column did not wrap"); // R4

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |=> $stable(page_q)) else $error("page moved on data"); // R3

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (int'(addr_q) < TOTAL)) else $error("write outside frame"); // R3

  AST_WRITE_REDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> redraw_q) else $error("write without redraw"); // R14
endmodule

// File: rtl/oled_byte_parser.sv
module oled_byte_parser
  import oled_parser_pkg::*;
#(
  parameter int COLS   = 132,
  parameter int PAGES  = 8,
  parameter int LINE_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          byte_valid,
  input  logic [7:0]                    byte_data,
  input  logic                          start_evt,
  input  logic                          stop_evt,
  input  logic                          read_req,
  output logic                          mem_we,
  output logic [$clog2(COLS*PAGES)-1:0] mem_addr,
  output logic [7:0]                    mem_wdata,
  output logic [COL_W-1:0]              col_ptr,
  output logic [$clog2(PAGES)-1:0]      page_ptr,
  output logic [LINE_W-1:0]             start_line,
  output logic                          flip,
  output logic                          all_lit,
  output logic                          invert,
  output logic                          panel_en,
  output logic                          sel_err,
  output logic                          cmd_err,
  output logic                          rd_unsup,
  output logic                          redraw
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       cmd_fire, data_fire, needs_param;
  logic       rd_q;
  op_t        dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  oled_opcode_decode i_decode (
    .op  (byte_data),
    .dec (dec)
  );

  assign needs_param = (dec.kind == OP_PARAM);

  oled_mode_fsm i_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .needs_param (needs_param),
    .cmd_fire    (cmd_fire),
    .data_fire   (data_fire),
    .sel_err     (sel_err)
  );

  oled_disp_state #(.COLS(COLS), .PAGES(PAGES), .LINE_W(LINE_W)) i_state (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cmd_fire   (cmd_fire),
    .data_fire  (data_fire),
    .byte_data  (byte_data),
    .dec        (dec),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .col_ptr    (col_ptr),
    .page_ptr   (page_ptr),
    .start_line (start_line),
    .flip       (flip),
    .all_lit    (all_lit),
    .invert     (invert),
    .panel_en   (panel_en),
    .cmd_err    (cmd_err),
    .redraw     (redraw)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rd_q <= 1'b0;
    else            rd_q <= read_req;
  end
  assign rd_unsup = rd_q;

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({sel_err, cmd_err, mem_we})) else $error("overlapping byte outcomes"); // R2

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    read_req |=> rd_unsup) else $error("read not flagged"); // R13
endmodule

// File: tb/test_oled_byte_parser.sv
module test_oled_byte_parser;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, byte_valid, start_evt, stop_evt, read_req;
  logic [7:0] byte_data;
  logic mem_we;
  logic [10:0] mem_addr;
  logic [7:0] mem_wdata, col_ptr;
  logic [2:0] page_ptr;
  logic [5:0] start_line;
  logic flip, all_lit, invert, panel_en, sel_err, cmd_err, rd_unsup, redraw;

  int ntests = 0;
  int nfails = 0;
  bit done = 1'b0;
  int mcol = 0;
  int mpage = 0;
  logic [18:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  oled_byte_parser i_oled_byte_parser (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .start_evt(start_evt), .stop_evt(stop_evt), .read_req(read_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .col_ptr(col_ptr), .page_ptr(page_ptr), .start_line(start_line),
    .flip(flip), .all_lit(all_lit), .invert(invert), .panel_en(panel_en),
    .sel_err(sel_err), .cmd_err(cmd_err), .rd_unsup(rd_unsup), .redraw(redraw)
  );

  task automatic chk(input string req, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected writes as the design produces them (R3, R4)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      ntests++;
      if (expq.size() == 0) begin
        nfails++;
        $display("FAIL R4: actual write 0x%0h@0x%0h expected none", mem_wdata, mem_addr);
      end else begin
        logic [18:0] e;
        e = expq.pop_front();
        if ({mem_addr, mem_wdata} != e) begin
          nfails++;
          $display("FAIL R3: actual 0x%0h@0x%0h expected 0x%0h@0x%0h",
                   mem_wdata, mem_addr, e[7:0], e[18:8]);
        end
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] op);
    send(8'h80);
    send(op);
  endtask

  task automatic pix(input logic [7:0] b);
    if (mcol < 132) expq.push_back({11'(mpage*132 + mcol), b});
    mcol = (mcol >= 131) ? 0 : mcol + 1;
    send(b);
  endtask

  task automatic event_pulse(input bit is_start);
    @(negedge clk);
    if (is_start) start_evt = 1'b1; else stop_evt = 1'b1;
    @(negedge clk);
    start_evt = 1'b0;
    stop_evt  = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfails++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; byte_valid = 1'b0; byte_data = 8'h00;
    start_evt = 1'b0; stop_evt = 1'b0; read_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 col", col_ptr, 0);
    chk("R1 page", page_ptr, 0);
    chk("R1 flags", {flip, all_lit, invert, panel_en, start_line}, 0);
    chk("R1 pulses", {mem_we, sel_err, cmd_err, redraw}, 0);

    // R2 bad selector
    send(8'h12);
    chk("R2 sel_err pulse", sel_err, 1);
    @(negedge clk);
    chk("R2 sel_err one cycle", sel_err, 0);

    // R6 nibble column assembly
    cmd(8'h05); cmd(8'h13);
    chk("R6 col nibbles", col_ptr, 8'h35);
    cmd(8'h07); cmd(8'h1A); cmd(8'h20);
    chk("R6 0x20 clears high nibble", col_ptr, 8'h07);
    cmd(8'h05); cmd(8'h13);
    // R7 page
    cmd(8'hB2);
    chk("R7 page", page_ptr, 2);
    mcol = 8'h35; mpage = 2;

    // R3 data stream
    send(8'h40);
    pix(8'hAA); pix(8'hBB); pix(8'hCC);
    chk("R3 col advance", col_ptr, 8'h38);
    chk("R3 page kept", page_ptr, 2);

    // R4 wrap at 131
    event_pulse(1'b0);
    cmd(8'h03); cmd(8'h18);
    chk("R6 col 131", col_ptr, 131);
    mcol = 131;
    send(8'h40);
    pix(8'h11); pix(8'h22);
    chk("R4 wrap col", col_ptr, 1);

    // R4 write past end suppressed
    event_pulse(1'b1);
    cmd(8'h1F); cmd(8'h0F);
    mcol = 255;
    send(8'h40);
    pix(8'h77);
    chk("R4 suppressed write", mem_we, 0);
    chk("R4 col reset", col_ptr, 0);
    chk("R4 queue drained", expq.size(), 0);

    // R12 stop event ends data mode
    event_pulse(1'b0);
    send(8'h55);
    chk("R12 byte after stop is selector", sel_err, 1);
    chk("R12 no write after stop", mem_we, 0);

    // R7 start line
    cmd(8'h6A);
    chk("R7 start line", start_line, 6'h2A);
    chk("R14 redraw on start change", redraw, 1);

    // R8 flags and R14 redraw on change only
    cmd(8'hA7);
    chk("R8 invert set", invert, 1);
    chk("R14 redraw on change", redraw, 1);
    cmd(8'hA7);
    chk("R14 no redraw on same value", redraw, 0);
    cmd(8'hA1); cmd(8'hA5); cmd(8'hAF);
    chk("R8 flip/all/en set", {flip, all_lit, panel_en}, 3'b111);
    cmd(8'hA0); cmd(8'hA6);
    chk("R8 flip/invert clear", {flip, invert, all_lit, panel_en}, 4'b0011);
    cmd(8'hA4); cmd(8'hAE);
    chk("R8 all/en clear", {all_lit, panel_en}, 2'b00);

    // R9 parameter skip: page command as parameter must be discarded
    cmd(8'h81);
    chk("R9 no err on param opcode", cmd_err, 0);
    cmd(8'hB5);
    chk("R9 parameter discarded", page_ptr, 2);
    cmd(8'hD9); cmd(8'hFF);
    chk("R9 skipped byte not decoded", cmd_err, 0);
    cmd(8'hB5);
    chk("R9 decoding resumes", page_ptr, 5);

    // R10 ignored opcodes
    cmd(8'hC4);
    chk("R10 C4 no err", cmd_err, 0);
    cmd(8'hE3);
    chk("R10 E3 no err", cmd_err, 0);
    chk("R10 state kept", {page_ptr, start_line, flip, invert}, {3'd5, 6'h2A, 2'b00});

    // R11 unknown opcode
    cmd(8'hFF);
    chk("R11 cmd_err pulse", cmd_err, 1);
    @(negedge clk);
    chk("R11 cmd_err one cycle", cmd_err, 0);
    cmd(8'hB3);
    chk("R11 keeps running", page_ptr, 3);

    // R5 back to selector after one command
    send(8'h80); send(8'hA6); send(8'hA7);
    chk("R5 next byte is selector", sel_err, 1);
    chk("R5 invert untouched", invert, 0);

    // R12 armed skip cleared by start event
    cmd(8'hA8);
    event_pulse(1'b1);
    cmd(8'hB6);
    chk("R12 skip cleared by event", page_ptr, 6);

    // R13 read request
    @(negedge clk); read_req = 1'b1;
    @(negedge clk); read_req = 1'b0;
    chk("R13 rd_unsup pulse", rd_unsup, 1);
    @(negedge clk);
    chk("R13 rd_unsup one cycle", rd_unsup, 0);

    repeat (3) @(negedge clk);
    chk("R3 all writes seen", expq.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfails);
    $finish;
  end
endmodule